// File: doc/BRIEF.md
# Way-Partitioned Reconfigurable Two-Level Cache Array

This block is a four-way set-associative data array whose ways are divided at run time into a fast first level and a slower second level. A two-bit configuration input chooses how many of the low-numbered ways form the first level (one, two or four). The remaining ways form a second level that never holds a copy of a line that is also in the first level. Lines are one data word wide and addressed by line address: the low address bits select the set, the rest form the tag.

A load enters through a valid/ready request channel and is answered through a valid/ready response channel that carries the data and a level code. A request is only accepted while the block is idle, so exactly one request is in flight. The first-level ways are searched first. A first-level hit answers after a latency that grows with the first-level width. Otherwise the second-level ways are searched, and a hit there answers after a fixed longer latency and exchanges the line with a first-level victim. A miss in both levels raises a refill request carrying the line address. The refill data is written into a first-level way, and the line it displaces moves down into the second level. The response channel applies back-pressure: the response stays valid and unchanged until the consumer takes it, and no new request is accepted before that. The refill request likewise holds its address until the refill port takes it.

Top module: `rcache_top`

## Requirements
- R1: After reset the block is idle: req_ready is 1, resp_valid and refill_req_valid are 0, and every line is invalid, so the first access to any address is a miss.
- R2: cfg_l1_sel selects the first-level width: 0 gives way 0 only, 1 gives ways 0 and 1, 2 and 3 give all four ways. Ways at or above that count form the second level.
- R3: A first-level hit raises resp_valid exactly 2, 3 or 4 clock edges after the accepting edge for a width of 1, 2 or 4 ways, with resp_level = 0 and the stored word on resp_data.
- R4: A second-level hit raises resp_valid exactly L2_LAT edges after the accepting edge with resp_level = 1. The line then moves to the first-level victim way and the victim line takes its second-level way, so no tag is ever valid in two ways of one set.
- R5: A miss in both levels raises refill_req_valid exactly L2_LAT edges after the accepting edge with refill_addr equal to the request address, holds both until refill_req_ready, and then raises refill_rsp_ready. The edge that takes refill_rsp_valid is followed by resp_valid with resp_level = 2 and resp_data equal to the refill word.
- R6: The first-level victim is chosen per set by a round-robin pointer taken modulo the first-level width, starting at way 0 and advancing on every fill and every exchange. On a refill, a valid displaced line goes to the lowest invalid second-level way, or to way 3 when none is invalid; with four first-level ways it is dropped.
- R7: The configuration is sampled only while idle; a change while a request is in flight has no effect on that request. Moving the boundary leaves every line in its way, and the line is then classified by its way index.
- R8: req_ready is 1 only while idle, so a second request is never accepted while one is in flight.
- R9: Once raised, resp_valid stays 1 with resp_data and resp_level unchanged until the edge that sees resp_ready; the block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_l1_sel | input | 2 | First-level width select (0: 1 way, 1: 2 ways, 2/3: 4 ways) |
| req_valid | input | 1 | Load request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Line address of the load |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Consumer takes the response |
| resp_data | output | DATA_W | Loaded word |
| resp_level | output | 2 | Where it hit: 0 first level, 1 second level, 2 refill |
| refill_req_valid | output | 1 | Refill request valid |
| refill_req_ready | input | 1 | Refill port takes the request |
| refill_addr | output | ADDR_W | Line address to refill |
| refill_rsp_valid | input | 1 | Refill word valid |
| refill_rsp_ready | output | 1 | Block waits for the refill word |
| refill_rsp_data | input | DATA_W | Refill word |

## Verification
The bench sweeps every width setting through the same fill, hit, eviction and re-reference pattern on one set, so that a victim pointer that ignored the width, or a displaced line placed in the wrong way, shows up as a wrong level code or a wrong latency on a later access. Exchange on a second-level hit is checked by reading the promoted line back at first-level latency and the demoted line at second-level latency; a design that copied instead of swapping would return the demoted line from the first level. Moving the boundary with lines in place and changing the configuration during a request catch a design that flushes on reconfiguration or takes its latency from the live input. Response and refill back-pressure is held for several cycles to catch data that changes or a handshake that drops early.

// File: rtl/rcache_pkg.sv
package rcache_pkg;
  localparam int NWAYS = 4;
  localparam int WAY_W = 2;

  typedef enum logic [1:0] {
    LVL_L1  = 2'd0,
    LVL_L2  = 2'd1,
    LVL_MEM = 2'd2
  } lvl_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_REFQ,
    ST_REFW,
    ST_RESP
  } st_e;

  // number of first-level ways for a select code
  function automatic logic [2:0] l1_width(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/rcache_store.sv
module rcache_store
  import rcache_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(SETS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [IDX_W-1:0]                 rd_set,
  output logic [NWAYS-1:0]                 rd_vld,
  output logic [NWAYS-1:0][TAG_W-1:0]      rd_tag,
  output logic [NWAYS-1:0][DATA_W-1:0]     rd_data,
  input  logic                             wa_en,
  input  logic [WAY_W-1:0]                 wa_way,
  input  logic                             wa_vld,
  input  logic [TAG_W-1:0]                 wa_tag,
  input  logic [DATA_W-1:0]                wa_data,
  input  logic                             wb_en,
  input  logic [WAY_W-1:0]                 wb_way,
  input  logic                             wb_vld,
  input  logic [TAG_W-1:0]                 wb_tag,
  input  logic [DATA_W-1:0]                wb_data
);
  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    logic [SETS-1:0]   vld_m;
    logic [TAG_W-1:0]  tag_m [SETS];
    logic [DATA_W-1:0] dat_m [SETS];
    logic              hit_a, hit_b;

    assign hit_a = wa_en && (wa_way == WAY_W'(w));
    assign hit_b = wb_en && (wb_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_m <= '0;
      end else if (hit_a) begin
        vld_m[rd_set] <= wa_vld;
      end else if (hit_b) begin
        vld_m[rd_set] <= wb_vld;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_a) begin
        tag_m[rd_set] <= wa_tag;
        dat_m[rd_set] <= wa_data;
      end else if (hit_b) begin
        tag_m[rd_set] <= wb_tag;
        dat_m[rd_set] <= wb_data;
      end
    end

    assign rd_vld[w]  = vld_m[rd_set];
    assign rd_tag[w]  = tag_m[rd_set];
    assign rd_data[w] = dat_m[rd_set];
  end
endmodule

// File: rtl/rcache_lookup.sv
module rcache_lookup
  import rcache_pkg::*;
#(
  parameter int TAG_W = 13
) (
  input  logic [NWAYS-1:0]            rd_vld,
  input  logic [NWAYS-1:0][TAG_W-1:0] rd_tag,
  input  logic [TAG_W-1:0]            tag_q,
  input  logic [2:0]                  l1_n,
  input  logic [WAY_W-1:0]            ptr,
  output logic                        l1_hit,
  output logic                        l2_hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic [WAY_W-1:0]            victim,
  output logic [WAY_W-1:0]            l2_slot,
  output logic                        has_l2,
  output logic [2:0]                  l1_lat
);
  logic [NWAYS-1:0] in_l1, match;

  for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
    assign in_l1[w] = (3'(w) < l1_n);
    assign match[w] = rd_vld[w] && (rd_tag[w] == tag_q);
  end

  assign l1_hit = |(match & in_l1);
  assign l2_hit = |(match & ~in_l1);
  assign has_l2 = (l1_n != 3'd4);
  assign victim = ptr & WAY_W'(l1_n - 3'd1);
  assign l1_lat = (l1_n == 3'd1) ? 3'd2 : (l1_n == 3'd2) ? 3'd3 : 3'd4;

  always_comb begin
    hit_way = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

  always_comb begin
    l2_slot = WAY_W'(NWAYS - 1);
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (!in_l1[w] && !rd_vld[w]) l2_slot = WAY_W'(w);
    end
  end
endmodule

// File: rtl/rcache_ctrl.sv
module rcache_ctrl
  import rcache_pkg::*;
#(
  parameter int L2_LAT = 8,
  parameter int CNT_W  = $clog2(L2_LAT + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       resp_ready,
  input  logic       refill_req_ready,
  input  logic       refill_rsp_valid,
  input  logic       l1_hit,
  input  logic       l2_hit,
  input  logic [2:0] l1_lat,
  output st_e        st,
  output logic       accept,
  output logic       l1_done,
  output logic       l2_done,
  output logic       fill_done
);
  logic [CNT_W-1:0] cnt;
  logic             look_end;

  assign accept    = (st == ST_IDLE) && req_valid;
  assign l1_done   = (st == ST_LOOK) && (cnt == CNT_W'(l1_lat)) && l1_hit;
  assign look_end  = (st == ST_LOOK) && (cnt == CNT_W'(L2_LAT));
  assign l2_done   = look_end && l2_hit;
  assign fill_done = (st == ST_REFW) && refill_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          st  <= ST_LOOK;
          cnt <= CNT_W'(1);
        end
        ST_LOOK: begin
          if (l1_done || l2_done) st <= ST_RESP;
          else if (look_end)      st <= ST_REFQ;
          else                    cnt <= cnt + 1'b1;
        end
        ST_REFQ: if (refill_req_ready) st <= ST_REFW;
        ST_REFW: if (fill_done)        st <= ST_RESP;
        ST_RESP: if (resp_ready)       st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rcache_top.sv
module rcache_top
  import rcache_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int L2_LAT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_l1_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [DATA_W-1:0] resp_data,
  output logic [1:0]        resp_level,
  output logic              refill_req_valid,
  input  logic              refill_req_ready,
  output logic [ADDR_W-1:0] refill_addr,
  input  logic              refill_rsp_valid,
  output logic              refill_rsp_ready,
  input  logic [DATA_W-1:0] refill_rsp_data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  st_e                          st;
  logic                         accept, l1_done, l2_done, fill_done;
  logic [ADDR_W-1:0]            addr_q;
  logic [1:0]                   cfg_q;
  logic [IDX_W-1:0]             idx_q;
  logic [TAG_W-1:0]             tag_q;
  logic [2:0]                   l1_n, l1_lat;
  logic [WAY_W-1:0]             ptr_m [SETS];
  logic [NWAYS-1:0]             rd_vld;
  logic [NWAYS-1:0][TAG_W-1:0]  rd_tag;
  logic [NWAYS-1:0][DATA_W-1:0] rd_data;
  logic                         l1_hit, l2_hit, has_l2;
  logic [WAY_W-1:0]             hit_way, victim, l2_slot;
  logic                         wa_en, wb_en, wb_vld;
  logic [TAG_W-1:0]             wa_tag, wb_tag;
  logic [DATA_W-1:0]            wa_data, wb_data;
  logic [WAY_W-1:0]             wb_way;
  logic [DATA_W-1:0]            data_q;
  logic [1:0]                   lvl_q;

  assign idx_q = addr_q[IDX_W-1:0];
  assign tag_q = addr_q[ADDR_W-1:IDX_W];
  assign l1_n  = l1_width(cfg_q);

  rcache_ctrl #(.L2_LAT(L2_LAT)) u_ctrl (
    .clk, .rst_n, .req_valid, .resp_ready, .refill_req_ready, .refill_rsp_valid,
    .l1_hit, .l2_hit, .l1_lat, .st, .accept, .l1_done, .l2_done, .fill_done
  );

  rcache_lookup #(.TAG_W(TAG_W)) u_look (
    .rd_vld, .rd_tag, .tag_q, .l1_n, .ptr(ptr_m[idx_q]),
    .l1_hit, .l2_hit, .hit_way, .victim, .l2_slot, .has_l2, .l1_lat
  );

  // writes: port A always targets the first-level victim, port B the second level
  assign wa_en   = l2_done || fill_done;
  assign wa_tag  = tag_q;
  assign wa_data = l2_done ? rd_data[hit_way] : refill_rsp_data;
  assign wb_en   = l2_done || (fill_done && has_l2 && rd_vld[victim]);
  assign wb_way  = l2_done ? hit_way : l2_slot;
  assign wb_vld  = rd_vld[victim];
  assign wb_tag  = rd_tag[victim];
  assign wb_data = rd_data[victim];

  rcache_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk, .rst_n, .rd_set(idx_q), .rd_vld, .rd_tag, .rd_data,
    .wa_en, .wa_way(victim), .wa_vld(1'b1), .wa_tag, .wa_data,
    .wb_en, .wb_way, .wb_vld, .wb_tag, .wb_data
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cfg_q  <= '0;
      data_q <= '0;
      lvl_q  <= LVL_L1;
      for (int s = 0; s < SETS; s++) ptr_m[s] <= '0;
    end else begin
      if (st == ST_IDLE) cfg_q <= cfg_l1_sel;
      if (accept) addr_q <= req_addr;
      if (l1_done) begin
        data_q <= rd_data[hit_way];
        lvl_q  <= LVL_L1;
      end else if (l2_done) begin
        data_q <= rd_data[hit_way];
        lvl_q  <= LVL_L2;
      end else if (fill_done) begin
        data_q <= refill_rsp_data;
        lvl_q  <= LVL_MEM;
      end
      if (wa_en) ptr_m[idx_q] <= ptr_m[idx_q] + 1'b1;
    end
  end

  assign req_ready        = (st == ST_IDLE);
  assign resp_valid       = (st == ST_RESP);
  assign resp_data        = data_q;
  assign resp_level       = lvl_q;
  assign refill_req_valid = (st == ST_REFQ);
  assign refill_addr      = addr_q;
  assign refill_rsp_ready = (st == ST_REFW);
endmodule

// File: rtl/rcache_chk.sv
module rcache_chk
  import rcache_pkg::*;
#(
  parameter int TAG_W  = 13,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int L2_LAT = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [1:0]                  cfg_l1_sel,
  input logic                        req_valid,
  input logic                        req_ready,
  input logic                        resp_valid,
  input logic                        resp_ready,
  input logic [DATA_W-1:0]           resp_data,
  input logic [1:0]                  resp_level,
  input logic                        refill_req_valid,
  input logic                        refill_req_ready,
  input logic [ADDR_W-1:0]           refill_addr,
  input logic [NWAYS-1:0]            rd_vld,
  input logic [NWAYS-1:0][TAG_W-1:0] rd_tag,
  input logic [1:0]                  cfg_q
);
  logic [4:0] cyc;
  logic [4:0] lat_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc     <= '0;
      lat_cap <= '0;
    end else if (req_valid && req_ready) begin
      cyc     <= '0;
      lat_cap <= (cfg_l1_sel == 2'd0) ? 5'd2 : (cfg_l1_sel == 2'd1) ? 5'd3 : 5'd4;
    end else if (cyc != 5'h1f) begin
      cyc <= cyc + 1'b1;
    end
  end

  function automatic logic dup_tag(input logic [NWAYS-1:0] v,
                                   input logic [NWAYS-1:0][TAG_W-1:0] t);
    for (int i = 0; i < NWAYS; i++)
      for (int j = i + 1; j < NWAYS; j++)
        if (v[i] && v[j] && t[i] == t[j]) return 1'b1;
    return 1'b0;
  endfunction

  AST_L1_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(resp_valid) && resp_level == 2'd0) |-> (cyc == lat_cap)); // R3
  AST_L2_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(resp_valid) && resp_level == 2'd1) |-> (cyc == 5'(L2_LAT))); // R4
  AST_NO_DUPLICATE: assert property (@(posedge clk) disable iff (!rst_n)
    !dup_tag(rd_vld, rd_tag)); // R4
  AST_REFILL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refill_req_valid) |-> (cyc == 5'(L2_LAT))); // R5
  AST_REFILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req_valid && !refill_req_ready) |=> (refill_req_valid && $stable(refill_addr))); // R5
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(cfg_q)); // R7
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid || refill_req_valid) |-> !req_ready); // R8
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data) && $stable(resp_level))); // R9
endmodule

bind rcache_top rcache_chk #(
  .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .L2_LAT(L2_LAT)
) chk_i (
  .clk, .rst_n, .cfg_l1_sel, .req_valid, .req_ready, .resp_valid, .resp_ready,
  .resp_data, .resp_level, .refill_req_valid, .refill_req_ready, .refill_addr,
  .rd_vld, .rd_tag, .cfg_q
);

// File: tb/rcache_top_tb_top.sv
module rcache_top_tb_top;
  localparam int SETS   = 8;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int L2_LAT = 8;
  localparam int LV_L1 = 0, LV_L2 = 1, LV_MEM = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        cfg_l1_sel = 2'd0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              resp_valid;
  logic              resp_ready = 1'b0;
  logic [DATA_W-1:0] resp_data;
  logic [1:0]        resp_level;
  logic              refill_req_valid;
  logic              refill_req_ready = 1'b0;
  logic [ADDR_W-1:0] refill_addr;
  logic              refill_rsp_valid = 1'b0;
  logic              refill_rsp_ready;
  logic [DATA_W-1:0] refill_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rcache_top #(.SETS(SETS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .L2_LAT(L2_LAT)) dut_i (
    .clk, .rst_n, .cfg_l1_sel, .req_valid, .req_ready, .req_addr,
    .resp_valid, .resp_ready, .resp_data, .resp_level,
    .refill_req_valid, .refill_req_ready, .refill_addr,
    .refill_rsp_valid, .refill_rsp_ready, .refill_rsp_data
  );

  function automatic logic [DATA_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return {a ^ 16'h5A5A, ~a};
  endfunction

  function automatic logic [ADDR_W-1:0] line(input int tag, input int set);
    return ADDR_W'(tag * SETS + set);
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one load; lat is ignored for a refill; mid_cfg >= 0 changes the select while busy
  task automatic access(input logic [ADDR_W-1:0] a, input int lvl, input int lat,
                        input string rq, input int mid_cfg);
    int cnt;
    logic [DATA_W-1:0] held;
    @(negedge clk);
    check(req_ready == 1'b1, "R8", "req_ready while idle", req_ready, 1);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R8", "req_ready while busy", req_ready, 0);
    if (mid_cfg >= 0) cfg_l1_sel = 2'(mid_cfg);
    cnt = 0;
    while (!resp_valid && !refill_req_valid && cnt < 40) begin
      @(posedge clk);
      #1;
      cnt++;
    end
    if (lvl == LV_MEM) begin
      check(refill_req_valid == 1'b1, rq, "refill raised on miss", refill_req_valid, 1);
      check(cnt == L2_LAT, "R5", "refill request latency", cnt, L2_LAT);
      check(refill_addr == a, "R5", "refill address", refill_addr, a);
      repeat (2) begin
        @(posedge clk);
        #1;
        check(refill_req_valid && refill_addr == a, "R5", "refill held", refill_addr, a);
      end
      refill_req_ready = 1'b1;
      @(posedge clk);
      #1;
      refill_req_ready = 1'b0;
      check(refill_rsp_ready == 1'b1, "R5", "refill_rsp_ready", refill_rsp_ready, 1);
      repeat (2) @(posedge clk);
      #1;
      check(resp_valid == 1'b0, "R5", "no response before refill word", resp_valid, 0);
      refill_rsp_valid = 1'b1;
      refill_rsp_data  = word_of(a);
      @(posedge clk);
      #1;
      refill_rsp_valid = 1'b0;
      check(resp_valid == 1'b1, "R5", "response after refill", resp_valid, 1);
    end else begin
      check(resp_valid == 1'b1, rq, "response raised", resp_valid, 1);
      check(cnt == lat, rq, "hit latency", cnt, lat);
    end
    check(resp_level == 2'(lvl), rq, "level code", resp_level, lvl);
    check(resp_data == word_of(a), rq, "data", resp_data, word_of(a));
    held = resp_data;
    repeat (2) begin
      @(posedge clk);
      #1;
      check(resp_valid && resp_data == held && !req_ready, "R9", "response held", resp_data, held);
    end
    resp_ready = 1'b1;
    @(posedge clk);
    #1;
    resp_ready = 1'b0;
    check(!resp_valid && req_ready, "R9", "idle after take", req_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    check(resp_valid == 1'b0, "R1", "resp_valid after reset", resp_valid, 0);
    check(refill_req_valid == 1'b0, "R1", "refill_req_valid after reset", refill_req_valid, 0);

    // sweep every width over the same fill / evict / re-reference pattern
    for (int c = 0; c < 3; c++) begin
      int n, lat, lv2;
      n   = 1 << c;
      lat = c + 2;
      lv2 = (n < 4) ? LV_L2 : LV_MEM;
      do_reset();
      cfg_l1_sel = 2'(c);
      for (int k = 1; k <= n; k++) access(line(k, 0), LV_MEM, 0, "R1", -1);
      for (int k = 1; k <= n; k++) access(line(k, 0), LV_L1, lat, "R3", -1);
      access(line(n + 1, 0), LV_MEM, 0, "R6", -1);
      access(line(1, 0), lv2, L2_LAT, "R6", -1);
      access(line(1, 0), LV_L1, lat, "R4", -1);
      access(line(2, 0), lv2, L2_LAT, "R4", -1);
      access(line(1, 5), LV_MEM, 0, "R6", -1);
      access(line(1, 5), LV_L1, lat, "R3", -1);
    end

    // select code 3 aliases four first-level ways
    do_reset();
    cfg_l1_sel = 2'd3;
    access(line(7, 2), LV_MEM, 0, "R2", -1);
    access(line(7, 2), LV_L1, 4, "R2", -1);

    // boundary moves with lines left in place
    do_reset();
    cfg_l1_sel = 2'd1;
    access(line(1, 3), LV_MEM, 0, "R7", -1);
    access(line(2, 3), LV_MEM, 0, "R7", -1);
    cfg_l1_sel = 2'd0;
    access(line(2, 3), LV_L2, L2_LAT, "R7", -1);
    access(line(1, 3), LV_L2, L2_LAT, "R7", -1);
    cfg_l1_sel = 2'd2;
    access(line(1, 3), LV_L1, 4, "R7", 0);
    cfg_l1_sel = 2'd2;
    access(line(2, 3), LV_L1, 4, "R2", -1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule